// File: doc/BRIEF.md
# Two-Level Write-Clear Interrupt Aggregator

This block collects interrupt events into five secondary status registers and one primary status register. It drives a single interrupt line that software services over a small register bus. Most secondary registers hold one bit per transmit queue for each event kind. Secondary register 2 also holds bus-error and beacon-timing flags. Ten primary bits are not stored at all: each one is the live OR of a group of secondary bits, so reading the primary register shows at once which groups need attention. A few extra primary bits are stored directly and are set by their own event inputs.

Software clears status by writing ones. It can clear single secondary bits, or it can write a one to a summary bit in the primary register to clear the whole secondary group behind it. A summary bit falls as soon as its group is empty. A primary mask, a mask for the secondary register 2 bits, and a global enable decide whether the output line is raised. A read-only pending register tells software in one bit whether a request is active.

Top module: `irq_agg`

## Requirements
- R1: After a synchronous reset every status, mask and enable register reads 0, and `irq_o` is low.
- R2: An event input pulse sets the matching bit in its secondary register. Writing a secondary register clears exactly the bits written as 1, and bits written as 0 keep their value.
- R3: Primary bit 0 is the OR of secondary 0 bits [NQ-1:0] and bit 1 is the OR of secondary 0 bits [2NQ-1:NQ]. Bits 2 and 3 are the ORs of the same two halves of secondary 1. Bits 7 and 8 are the ORs of the same two halves of secondary 3. Bit 9 is the OR of secondary 4 bits [NQ-1:0].
- R4: Secondary 2 holds per-queue underrun bits in [NQ-1:0], three bus-error bits in [NQ+2:NQ] and six beacon bits in [NQ+8:NQ+3]. Each of these bits is ANDed with the secondary mask (address 7) before the ORs form primary bit 4 (underrun), primary bit 5 (bus error) and primary bit 6 (beacon).
- R5: Writing 1 to a summary bit (primary bits 0 to 9, address 0) clears every secondary bit in that bit's group. The summary bit then reads 0.
- R6: Primary bits 10 and up are stored. They are set by `ev_dir_i` and cleared when written as 1 at address 0.
- R7: If an event sets a bit in the same cycle that a write of 1 would clear it, the bit ends up set.
- R8: `irq_o` is high one cycle after the global enable (address 8, bit 0; 1 enables, 0 disables) is 1 while at least one primary bit is set together with its primary mask bit (address 6).
- R9: The pending register (address 9) reads 1 while the request condition of R8 holds, and 0 otherwise.
- R10: Read data appears on `bus_rdata_o` one cycle after the address is presented. Addresses: 0 primary, 1 to 5 secondary 0 to 4, 6 primary mask, 7 secondary mask, 8 enable, 9 pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 4 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data |
| ev_s0_i | input | 2*NQ | Event pulses into secondary 0 |
| ev_s1_i | input | 2*NQ | Event pulses into secondary 1 |
| ev_s2_i | input | NQ+9 | Event pulses into secondary 2 |
| ev_s3_i | input | 2*NQ | Event pulses into secondary 3 |
| ev_s4_i | input | NQ | Event pulses into secondary 4 |
| ev_dir_i | input | NDIR | Event pulses into stored primary bits |
| irq_o | output | 1 | Interrupt request line |

## Verification
The properties check four things on every cycle: that the line stays low after reset, that a group clear empties its queue field, that an event is never lost to a simultaneous clear, and that a stored bit written with 0 survives. They also check that the line only rises after the enable was set and that the pending read is never wider than one bit. The bench scenarios are needed for the rest: the exact group-to-summary mapping, the gating by the secondary mask, the partial secondary clears, and the interplay of mask, enable and pending readback.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int AW      = 4;
  localparam int NSUM    = 10;
  localparam int S2_MISC = 9;

  localparam int P_TXOK  = 0;
  localparam int P_TXDSC = 1;
  localparam int P_TXERR = 2;
  localparam int P_TXEOL = 3;
  localparam int P_TXURN = 4;
  localparam int P_HIU   = 5;
  localparam int P_BCN   = 6;
  localparam int P_ORN   = 7;
  localparam int P_URN   = 8;
  localparam int P_TRIG  = 9;

  localparam logic [AW-1:0] A_PRIM  = 4'd0;
  localparam logic [AW-1:0] A_S0    = 4'd1;
  localparam logic [AW-1:0] A_S1    = 4'd2;
  localparam logic [AW-1:0] A_S2    = 4'd3;
  localparam logic [AW-1:0] A_S3    = 4'd4;
  localparam logic [AW-1:0] A_S4    = 4'd5;
  localparam logic [AW-1:0] A_PMASK = 4'd6;
  localparam logic [AW-1:0] A_SMASK = 4'd7;
  localparam logic [AW-1:0] A_GEN   = 4'd8;
  localparam logic [AW-1:0] A_PEND  = 4'd9;
endpackage

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set has priority over clear
  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= '0;
    else       q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_agg_sum.sv
module irq_agg_sum import irq_agg_pkg::*; #(
  parameter int NQ = 4
) (
  input  logic [2*NQ-1:0]      s0_i,
  input  logic [2*NQ-1:0]      s1_i,
  input  logic [NQ+S2_MISC-1:0] s2_i,
  input  logic [NQ+S2_MISC-1:0] s2_mask_i,
  input  logic [2*NQ-1:0]      s3_i,
  input  logic [NQ-1:0]        s4_i,
  output logic [NSUM-1:0]      sum_o
);
  logic [NQ+S2_MISC-1:0] s2m;

  always_comb begin
    s2m            = s2_i & s2_mask_i;
    sum_o          = '0;
    sum_o[P_TXOK]  = |s0_i[NQ-1:0];
    sum_o[P_TXDSC] = |s0_i[2*NQ-1:NQ];
    sum_o[P_TXERR] = |s1_i[NQ-1:0];
    sum_o[P_TXEOL] = |s1_i[2*NQ-1:NQ];
    sum_o[P_TXURN] = |s2m[NQ-1:0];
    sum_o[P_HIU]   = |s2m[NQ+2:NQ];
    sum_o[P_BCN]   = |s2m[NQ+8:NQ+3];
    sum_o[P_ORN]   = |s3_i[NQ-1:0];
    sum_o[P_URN]   = |s3_i[2*NQ-1:NQ];
    sum_o[P_TRIG]  = |s4_i;
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg import irq_agg_pkg::*; #(
  parameter int NQ   = 4,
  parameter int NDIR = 4,
  parameter int DW   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic [AW-1:0]         bus_addr_i,
  input  logic                  bus_we_i,
  input  logic [DW-1:0]         bus_wdata_i,
  output logic [DW-1:0]         bus_rdata_o,
  input  logic [2*NQ-1:0]       ev_s0_i,
  input  logic [2*NQ-1:0]       ev_s1_i,
  input  logic [NQ+S2_MISC-1:0] ev_s2_i,
  input  logic [2*NQ-1:0]       ev_s3_i,
  input  logic [NQ-1:0]         ev_s4_i,
  input  logic [NDIR-1:0]       ev_dir_i,
  output logic                  irq_o
);
  localparam int PW  = NSUM + NDIR;
  localparam int S0W = 2 * NQ;
  localparam int S2W = NQ + S2_MISC;
  localparam int S4W = NQ;

  logic [S0W-1:0]  s0_q, s1_q, s3_q, clr0, clr1, clr3;
  logic [S2W-1:0]  s2_q, clr2, smask_q;
  logic [S4W-1:0]  s4_q, clr4;
  logic [NDIR-1:0] dir_q, clr_dir;
  logic [NSUM-1:0] sum;
  logic [PW-1:0]   prim, pmask_q, pw;
  logic            gen_q, req, wr_prim;

  assign wr_prim = bus_we_i && (bus_addr_i == A_PRIM);
  assign pw      = wr_prim ? bus_wdata_i[PW-1:0] : '0;

  // software clears: direct write-one plus group clears from the primary
  always_comb begin
    clr0 = '0; clr1 = '0; clr2 = '0; clr3 = '0; clr4 = '0;
    if (bus_we_i) begin
      case (bus_addr_i)
        A_S0:    clr0 = bus_wdata_i[S0W-1:0];
        A_S1:    clr1 = bus_wdata_i[S0W-1:0];
        A_S2:    clr2 = bus_wdata_i[S2W-1:0];
        A_S3:    clr3 = bus_wdata_i[S0W-1:0];
        A_S4:    clr4 = bus_wdata_i[S4W-1:0];
        default: ;
      endcase
    end
    clr0 = clr0 | {{NQ{pw[P_TXDSC]}}, {NQ{pw[P_TXOK]}}};
    clr1 = clr1 | {{NQ{pw[P_TXEOL]}}, {NQ{pw[P_TXERR]}}};
    clr2[NQ-1:0]    = clr2[NQ-1:0]    | {NQ{pw[P_TXURN]}};
    clr2[NQ+2:NQ]   = clr2[NQ+2:NQ]   | {3{pw[P_HIU]}};
    clr2[NQ+8:NQ+3] = clr2[NQ+8:NQ+3] | {6{pw[P_BCN]}};
    clr3 = clr3 | {{NQ{pw[P_URN]}}, {NQ{pw[P_ORN]}}};
    clr4 = clr4 | {NQ{pw[P_TRIG]}};
    clr_dir = pw[PW-1:NSUM];
  end

  irq_agg_bank #(.W(S0W))  u_s0  (.clk_i, .rst_i, .set_i(ev_s0_i),  .clr_i(clr0),    .q_o(s0_q));
  irq_agg_bank #(.W(S0W))  u_s1  (.clk_i, .rst_i, .set_i(ev_s1_i),  .clr_i(clr1),    .q_o(s1_q));
  irq_agg_bank #(.W(S2W))  u_s2  (.clk_i, .rst_i, .set_i(ev_s2_i),  .clr_i(clr2),    .q_o(s2_q));
  irq_agg_bank #(.W(S0W))  u_s3  (.clk_i, .rst_i, .set_i(ev_s3_i),  .clr_i(clr3),    .q_o(s3_q));
  irq_agg_bank #(.W(S4W))  u_s4  (.clk_i, .rst_i, .set_i(ev_s4_i),  .clr_i(clr4),    .q_o(s4_q));
  irq_agg_bank #(.W(NDIR)) u_dir (.clk_i, .rst_i, .set_i(ev_dir_i), .clr_i(clr_dir), .q_o(dir_q));

  irq_agg_sum #(.NQ(NQ)) u_sum (
    .s0_i(s0_q), .s1_i(s1_q), .s2_i(s2_q), .s2_mask_i(smask_q),
    .s3_i(s3_q), .s4_i(s4_q), .sum_o(sum)
  );

  assign prim = {dir_q, sum};
  assign req  = gen_q & (|(prim & pmask_q));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pmask_q <= '0;
      smask_q <= '0;
      gen_q   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= req;
      if (bus_we_i) begin
        case (bus_addr_i)
          A_PMASK: pmask_q <= bus_wdata_i[PW-1:0];
          A_SMASK: smask_q <= bus_wdata_i[S2W-1:0];
          A_GEN:   gen_q   <= bus_wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) bus_rdata_o <= '0;
    else begin
      case (bus_addr_i)
        A_PRIM:  bus_rdata_o <= DW'(prim);
        A_S0:    bus_rdata_o <= DW'(s0_q);
        A_S1:    bus_rdata_o <= DW'(s1_q);
        A_S2:    bus_rdata_o <= DW'(s2_q);
        A_S3:    bus_rdata_o <= DW'(s3_q);
        A_S4:    bus_rdata_o <= DW'(s4_q);
        A_PMASK: bus_rdata_o <= DW'(pmask_q);
        A_SMASK: bus_rdata_o <= DW'(smask_q);
        A_GEN:   bus_rdata_o <= DW'(gen_q);
        A_PEND:  bus_rdata_o <= DW'(req);
        default: bus_rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk import irq_agg_pkg::*; #(
  parameter int NQ   = 4,
  parameter int NDIR = 4,
  parameter int DW   = 32
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic            bus_we_i,
  input logic [AW-1:0]   bus_addr_i,
  input logic [DW-1:0]   bus_wdata_i,
  input logic [DW-1:0]   bus_rdata_o,
  input logic [2*NQ-1:0] ev_s0_i,
  input logic [2*NQ-1:0] s0_q,
  input logic [NDIR-1:0] ev_dir_i,
  input logic [NDIR-1:0] dir_q,
  input logic            gen_q,
  input logic            irq_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> !irq_o); // R1

  AST_GROUP_EMPTIES: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_we_i && bus_addr_i == A_PRIM && bus_wdata_i[P_TXOK] && ev_s0_i[NQ-1:0] == '0)
    |=> s0_q[NQ-1:0] == '0); // R5

  AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_we_i && bus_addr_i == A_PRIM && dir_q[0] && !bus_wdata_i[NSUM])
    |=> dir_q[0]); // R6

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    (|ev_dir_i) |=> ((dir_q & $past(ev_dir_i)) == $past(ev_dir_i))); // R7

  AST_LINE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> $past(gen_q)); // R8

  AST_PEND_ONE_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(bus_addr_i) == A_PEND) |-> (bus_rdata_o[DW-1:1] == '0)); // R9
endmodule

bind irq_agg irq_agg_chk #(.NQ(NQ), .NDIR(NDIR), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .ev_s0_i(ev_s0_i),
  .s0_q(s0_q), .ev_dir_i(ev_dir_i), .dir_q(dir_q), .gen_q(gen_q), .irq_o(irq_o)
);

// File: tb/irq_agg_tb.sv
module irq_agg_tb;
  localparam int NQ = 4, NDIR = 4, DW = 32;
  localparam logic [3:0] OP_RD = 4'd0, OP_WR = 4'd1, OP_EV = 4'd2;
  // entry: {req, op, addr, data, expect}; for OP_EV addr 0=direct, 1..5=secondary 0..4
  localparam int NV = 33;
  localparam logic [43:0] VEC [NV] = '{
    {4'd1,  OP_RD, 4'd0, 16'h0000, 16'h0000},  // R1 primary
    {4'd9,  OP_RD, 4'd9, 16'h0000, 16'h0000},  // R9 pending
    {4'd2,  OP_EV, 4'd1, 16'h0002, 16'h0000},
    {4'd2,  OP_RD, 4'd1, 16'h0000, 16'h0002},  // R2 set
    {4'd3,  OP_RD, 4'd0, 16'h0000, 16'h0001},  // R3 txok summary
    {4'd2,  OP_EV, 4'd1, 16'h0040, 16'h0000},
    {4'd3,  OP_RD, 4'd0, 16'h0000, 16'h0003},  // R3
    {4'd2,  OP_WR, 4'd1, 16'h0002, 16'h0000},
    {4'd2,  OP_RD, 4'd1, 16'h0000, 16'h0040},  // R2 partial clear
    {4'd2,  OP_WR, 4'd1, 16'h0000, 16'h0000},
    {4'd2,  OP_RD, 4'd1, 16'h0000, 16'h0040},  // R2 zero write
    {4'd2,  OP_EV, 4'd2, 16'h0081, 16'h0000},
    {4'd3,  OP_RD, 4'd0, 16'h0000, 16'h000E},  // R3 secondary 1
    {4'd5,  OP_WR, 4'd0, 16'h0004, 16'h0000},
    {4'd5,  OP_RD, 4'd2, 16'h0000, 16'h0080},  // R5 group clear
    {4'd5,  OP_RD, 4'd0, 16'h0000, 16'h000A},  // R5 summary falls
    {4'd4,  OP_EV, 4'd3, 16'h00A1, 16'h0000},
    {4'd4,  OP_RD, 4'd3, 16'h0000, 16'h00A1},  // R4 layout
    {4'd4,  OP_RD, 4'd0, 16'h0000, 16'h000A},  // R4 gated by mask
    {4'd4,  OP_WR, 4'd7, 16'h1FFF, 16'h0000},
    {4'd4,  OP_RD, 4'd0, 16'h0000, 16'h007A},  // R4 unmasked
    {4'd5,  OP_WR, 4'd0, 16'h0040, 16'h0000},
    {4'd5,  OP_RD, 4'd3, 16'h0000, 16'h0021},  // R5 beacon group
    {4'd5,  OP_RD, 4'd0, 16'h0000, 16'h003A},  // R5
    {4'd3,  OP_EV, 4'd4, 16'h0010, 16'h0000},
    {4'd3,  OP_EV, 4'd5, 16'h0008, 16'h0000},
    {4'd3,  OP_RD, 4'd0, 16'h0000, 16'h033A},  // R3 secondary 3 and 4
    {4'd6,  OP_EV, 4'd0, 16'h0005, 16'h0000},
    {4'd6,  OP_RD, 4'd0, 16'h0000, 16'h173A},  // R6 stored bits
    {4'd6,  OP_WR, 4'd0, 16'h0400, 16'h0000},
    {4'd6,  OP_RD, 4'd0, 16'h0000, 16'h133A},  // R6 clear
    {4'd10, OP_WR, 4'd6, 16'h1000, 16'h0000},
    {4'd10, OP_RD, 4'd6, 16'h0000, 16'h1000}   // R10 mask readback
  };

  logic clk = 1'b0, rst = 1'b1, we = 1'b0, irq;
  logic [3:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [2*NQ-1:0] e0 = '0, e1 = '0, e3 = '0;
  logic [NQ+8:0] e2 = '0;
  logic [NQ-1:0] e4 = '0;
  logic [NDIR-1:0] ed = '0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_agg #(.NQ(NQ), .NDIR(NDIR), .DW(DW)) u_dut (
    .clk_i(clk), .rst_i(rst), .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .ev_s0_i(e0), .ev_s1_i(e1), .ev_s2_i(e2), .ev_s3_i(e3),
    .ev_s4_i(e4), .ev_dir_i(ed), .irq_o(irq)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); addr = a;
    @(negedge clk); check(rdata, exp, tag);
  endtask

  task automatic do_ev(input logic [3:0] t, input logic [15:0] p);
    @(negedge clk);
    case (t)
      4'd0: ed = p[NDIR-1:0];
      4'd1: e0 = p[2*NQ-1:0];
      4'd2: e1 = p[2*NQ-1:0];
      4'd3: e2 = p[NQ+8:0];
      4'd4: e3 = p[2*NQ-1:0];
      default: e4 = p[NQ-1:0];
    endcase
    @(negedge clk); ed = '0; e0 = '0; e1 = '0; e2 = '0; e3 = '0; e4 = '0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check({31'd0, irq}, 0, "R1 irq after reset");
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][39:36])
        OP_RD: do_rd(VEC[i][35:32], DW'(VEC[i][15:0]), $sformatf("R%0d vec %0d", VEC[i][43:40], i));
        OP_WR: do_wr(VEC[i][35:32], DW'(VEC[i][31:16]));
        default: do_ev(VEC[i][35:32], VEC[i][31:16]);
      endcase
    end
    // R8 / R9: mask set but disabled, then enabled
    do_rd(4'd9, 0, "R9 pending while disabled");
    check({31'd0, irq}, 0, "R8 irq while disabled");
    do_wr(4'd8, 1);
    do_rd(4'd9, 1, "R9 pending when enabled");
    check({31'd0, irq}, 1, "R8 irq when enabled");
    do_wr(4'd8, 0);
    do_rd(4'd9, 0, "R9 pending after disable");
    check({31'd0, irq}, 0, "R8 irq after disable");
    do_wr(4'd8, 1);
    do_wr(4'd0, 32'h1000);
    do_rd(4'd9, 0, "R9 pending after source cleared");
    check({31'd0, irq}, 0, "R8 irq after source cleared");
    do_rd(4'd0, 32'h033A, "R6 primary after clear");
    // R7: set and clear in the same cycle
    @(negedge clk); ed = 4'h8; addr = 4'd0; wdata = 32'h2000; we = 1'b1;
    @(negedge clk); ed = '0; we = 1'b0; wdata = '0;
    do_rd(4'd0, 32'h233A, "R7 direct set wins");
    @(negedge clk); e4 = 4'h1; addr = 4'd5; wdata = 32'h1; we = 1'b1;
    @(negedge clk); e4 = '0; we = 1'b0; wdata = '0;
    do_rd(4'd5, 32'h9, "R7 secondary set wins");
    // R1: reset again from a busy state
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    do_rd(4'd0, 0, "R1 primary cleared");
    do_rd(4'd7, 0, "R1 secondary mask cleared");
    do_rd(4'd8, 0, "R1 enable cleared");
    check({31'd0, irq}, 0, "R1 irq low");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule